// File: doc/BRIEF.md
# Double-Buffered Audio Pulse-Width Timer

This block turns a stream of audio samples into pulse widths on a pair of complementary outputs. A 16-bit up-counter runs from zero to a programmed period limit and then wraps, so each period lasts the limit plus one count clock. While the counter is below the active sample value, the high-side output holds the opposite of a programmed idle level. The low-side output is always its inverse.

Samples arrive through a register-style write port into a holding buffer. The buffer moves into the active compare register when counting starts. After that it moves each time a programmable number of periods has elapsed, so each sample lasts (repeat + 1) periods. Every move raises a buffer-empty flag. The flag drives an interrupt, when enabled, and a DMA request, so that software or a DMA engine can supply the next sample just in time. A second flag reports when the counter reaches the active sample value. An 8-bit resolution mode places the sample in the upper byte and silences that flag.

Setting the run bit does not start counting. It only opens the request path. Counting begins on the first cycle after run is set in which the buffer holds a sample. Clearing run forces the idle level at once. The counter finishes the current group of periods and then halts.

Top module: `audio_pwm_timer`

## Requirements
- R1: A write to address 0 with bit 0 set (and also `rst_n` low) clears the counter, the repeat counter, the sample buffer, the active compare value, the period limit, the run bit and the compare-hit flag. It sets the buffer-empty flag to 1. On the next cycle `irq` and `dma_req` are 0 and `pwm_hi` equals the idle level, which is taken from bit 1 of the same write.
- R2: A write to address 1 with bit 0 = 1 sets run. With the buffer empty, `dma_req` goes to 1, and `irq` goes to 1 if the buffer-empty interrupt enable (address 5, bit 0) is set. The outputs stay at the idle level until a sample is written.
- R3: On the first cycle in which run is 1, the block is idle and the buffer holds a sample, the sample moves to the active register and counting starts at 0. On the next cycle `buf_empty` = 1, `dma_req` = 1 and the high-side output is in its active state (for a nonzero sample).
- R4: The period lasts (limit + 1) cycles, where the limit is written at address 3. Within each period the high-side output differs from the idle level for exactly `sample` cycles, at counter values 0 to sample-1.
- R5: With a repeat value N written at address 4 (bits 3:0), a sample written while counting first takes effect after the current group of N+1 periods ends.
- R6: If no new sample has been written when a reload is due, the active value is kept and the pulse width repeats unchanged.
- R7: When run is set and the counter equals the active value, `match_flag` becomes 1. `irq` is 1 while the flag is set and the compare interrupt enable (address 5, bit 1) is 1. Writing address 6 with bit 0 set clears the flag.
- R8: When bit 2 of the address-0 write is 1 (8-bit resolution), a sample write stores `wr_data[7:0]` into bits 15:8 of the buffer and zeros into bits 7:0, and `match_flag` is never set.
- R9: Writing run = 0 drives `pwm_hi` to the idle level and drops `dma_req` and `irq` on the next cycle. The counter completes the current group of periods and then halts. After a later run = 1, counting waits for a new sample.
- R10: `pwm_lo` is always the inverse of `pwm_hi`, in reset, while idle and while counting.
- R11: A sample write (address 2) clears `buf_empty` and `dma_req` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 run, 2 sample, 3 period limit, 4 repeat, 5 interrupt enables, 6 flag clear |
| wr_data | input | 16 | Register write data |
| buf_empty | output | 1 | Sample buffer is empty |
| match_flag | output | 1 | Counter reached the active sample value |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | Request for the next sample |
| pwm_hi | output | 1 | High-side pulse output |
| pwm_lo | output | 1 | Low-side pulse output, inverse of `pwm_hi` |

## Verification
The hardest case to reach is a sample that waits in the buffer while an older one plays. The bench has to write the buffer exactly one cycle after counting starts, so that the write does not collide with the start transfer. It then has to follow the pulse widths over several groups of periods to see when the new value takes effect, and afterwards that the value persists once the buffer is empty again. The stop case is similar. The bench clears run in the middle of a group, waits past the remaining periods, and sets run again without a sample, to show that counting stays halted until a fresh write.

// File: rtl/pwm_tmr_pkg.sv
// Shared definitions for the audio pulse-width timer.
// Assumes a 3-bit register address space; control bit positions fixed here.
package pwm_tmr_pkg;
    typedef enum logic [2:0] {
        ADR_CTRL   = 3'd0,
        ADR_RUN    = 3'd1,
        ADR_SAMPLE = 3'd2,
        ADR_PERIOD = 3'd3,
        ADR_REPEAT = 3'd4,
        ADR_IEN    = 3'd5,
        ADR_FLAGS  = 3'd6
    } reg_addr_e;

    localparam int CTRL_RST_BIT  = 0;
    localparam int CTRL_IDLE_BIT = 1;
    localparam int CTRL_RES8_BIT = 2;
    localparam int IEN_EMPTY_BIT = 0;
    localparam int IEN_MATCH_BIT = 1;
endpackage

// File: rtl/pwm_tmr_regs.sv
// Register write decode for the audio pulse-width timer.
// Holds configuration, run bit and produces one-cycle strobes for soft
// reset, sample writes and flag clears. Assumes CNT_W > 8.
module pwm_tmr_regs
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int REP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             soft_rst,
    output logic             idle_lvl,
    output logic             res8,
    output logic             run,
    output logic [CNT_W-1:0] period_val,
    output logic [REP_W-1:0] repeat_val,
    output logic             ie_empty,
    output logic             ie_match,
    output logic             smp_wr,
    output logic [CNT_W-1:0] smp_data,
    output logic             match_clr
);
    localparam int LOW_W = CNT_W - 8;

    reg_addr_e adr;

    // Decode the address and form write strobes.
    always_comb begin
        adr       = reg_addr_e'(wr_addr);
        soft_rst  = wr_en && (adr == ADR_CTRL) && wr_data[CTRL_RST_BIT];
        smp_wr    = wr_en && (adr == ADR_SAMPLE);
        match_clr = wr_en && (adr == ADR_FLAGS) && wr_data[0];
        smp_data  = res8 ? {wr_data[7:0], {LOW_W{1'b0}}} : wr_data;
    end

    // Configuration registers; soft reset clears run and period limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_lvl   <= 1'b0;
            res8       <= 1'b0;
            run        <= 1'b0;
            period_val <= '0;
            repeat_val <= '0;
            ie_empty   <= 1'b0;
            ie_match   <= 1'b0;
        end else if (wr_en) begin
            case (adr)
                ADR_CTRL: begin
                    idle_lvl <= wr_data[CTRL_IDLE_BIT];
                    res8     <= wr_data[CTRL_RES8_BIT];
                    if (wr_data[CTRL_RST_BIT]) begin
                        run        <= 1'b0;
                        period_val <= '0;
                    end
                end
                ADR_RUN:    run        <= wr_data[0];
                ADR_PERIOD: period_val <= wr_data;
                ADR_REPEAT: repeat_val <= wr_data[REP_W-1:0];
                ADR_IEN: begin
                    ie_empty <= wr_data[IEN_EMPTY_BIT];
                    ie_match <= wr_data[IEN_MATCH_BIT];
                end
                default: ;
            endcase
        end
    end

    // R1: a soft reset write leaves run cleared
    assert_soft_rst_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !run);
endmodule

// File: rtl/pwm_tmr_period.sv
// Period counter and repeat counter for the audio pulse-width timer.
// Starts when run is set and a sample is ready, wraps after the period
// limit, and reloads after (repeat + 1) wraps. Stops at the end of a group
// once run is cleared.
module pwm_tmr_period #(
    parameter int CNT_W = 16,
    parameter int REP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             run,
    input  logic             smp_ready,
    input  logic [CNT_W-1:0] period_val,
    input  logic [REP_W-1:0] repeat_val,
    output logic [CNT_W-1:0] cnt,
    output logic             active,
    output logic             start,
    output logic             reload
);
    logic [REP_W-1:0] grp_cnt;
    logic             wrap;
    logic             grp_end;

    // Start, wrap and reload conditions.
    always_comb begin
        start   = run && !active && smp_ready;
        wrap    = active && (cnt == period_val);
        grp_end = (grp_cnt == repeat_val);
        reload  = wrap && grp_end && run;
    end

    // Counter, group counter and activity state.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cnt     <= '0;
            grp_cnt <= '0;
            active  <= 1'b0;
        end else if (start) begin
            cnt     <= '0;
            grp_cnt <= '0;
            active  <= 1'b1;
        end else if (active) begin
            if (wrap) begin
                cnt <= '0;
                if (grp_end) begin
                    grp_cnt <= '0;
                    if (!run) active <= 1'b0;
                end else begin
                    grp_cnt <= grp_cnt + 1'b1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R3: counting begins at zero right after a start
    assert_start_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !soft_rst) |=> (active && cnt == '0));
    // R4: inside a period the counter advances by one each cycle
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !wrap && !soft_rst) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
    // R9: a group end with run cleared halts the counter
    assert_stop_at_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && grp_end && !run && !soft_rst) |=> !active);
    // R5: a wrap inside a group keeps counting
    assert_group_continue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !grp_end && !soft_rst) |=> active);
endmodule

// File: rtl/pwm_tmr_sample.sv
// Sample double buffer and flags for the audio pulse-width timer.
// The buffer moves to the active compare register on a transfer request
// when it holds a sample; the empty flag and compare-hit flag live here.
module pwm_tmr_sample #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             smp_wr,
    input  logic [CNT_W-1:0] smp_data,
    input  logic             xfer,
    input  logic             match_clr,
    input  logic             res8,
    input  logic             run,
    input  logic             active,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cmp_act,
    output logic             buf_empty,
    output logic             match_flag
);
    logic [CNT_W-1:0] sbuf;
    logic             hit;

    // Compare-hit condition, silenced in 8-bit resolution.
    always_comb hit = run && active && (cnt == cmp_act) && !res8;

    // Buffer, active register and flags; writes win over transfers.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            sbuf       <= '0;
            cmp_act    <= '0;
            buf_empty  <= 1'b1;
            match_flag <= 1'b0;
        end else begin
            if (smp_wr) begin
                sbuf      <= smp_data;
                buf_empty <= 1'b0;
            end else if (xfer && !buf_empty) begin
                buf_empty <= 1'b1;
            end
            if (xfer && !buf_empty) cmp_act <= sbuf;
            if (hit)            match_flag <= 1'b1;
            else if (match_clr) match_flag <= 1'b0;
        end
    end

    // R1: soft reset empties the buffer and clears compare state
    assert_soft_rst_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (buf_empty && !match_flag && cmp_act == '0));
    // R3: a transfer moves the held sample and marks the buffer empty
    assert_xfer_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !buf_empty && !smp_wr && !soft_rst) |=> (buf_empty && cmp_act == $past(sbuf)));
    // R6: a reload with no new sample keeps the active value
    assert_keep_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && buf_empty && !soft_rst) |=> $stable(cmp_act));
    // R8: 8-bit resolution never raises the compare-hit flag
    assert_res8_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res8 && !match_flag) |=> !match_flag);
    // R11: a sample write fills the buffer
    assert_write_fills_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_wr && !soft_rst) |=> !buf_empty);
endmodule

// File: rtl/audio_pwm_timer.sv
// Top of the double-buffered audio pulse-width timer.
// Joins register decode, period counter and sample buffer, and forms the
// complementary outputs and the interrupt and DMA requests.
// Assumes one count per clock cycle.
module audio_pwm_timer #(
    parameter int CNT_W = 16,
    parameter int REP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             buf_empty,
    output logic             match_flag,
    output logic             irq,
    output logic             dma_req,
    output logic             pwm_hi,
    output logic             pwm_lo
);
    logic             soft_rst, idle_lvl, res8, run;
    logic             ie_empty, ie_match, smp_wr, match_clr;
    logic [CNT_W-1:0] period_val, smp_data, cnt, cmp_act;
    logic [REP_W-1:0] repeat_val;
    logic             active, start, reload, pulse;

    pwm_tmr_regs #(.CNT_W(CNT_W), .REP_W(REP_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .soft_rst(soft_rst), .idle_lvl(idle_lvl),
        .res8(res8), .run(run), .period_val(period_val),
        .repeat_val(repeat_val), .ie_empty(ie_empty), .ie_match(ie_match),
        .smp_wr(smp_wr), .smp_data(smp_data), .match_clr(match_clr)
    );

    pwm_tmr_period #(.CNT_W(CNT_W), .REP_W(REP_W)) u_period (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .run(run),
        .smp_ready(!buf_empty), .period_val(period_val),
        .repeat_val(repeat_val), .cnt(cnt), .active(active),
        .start(start), .reload(reload)
    );

    pwm_tmr_sample #(.CNT_W(CNT_W)) u_sample (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .smp_wr(smp_wr),
        .smp_data(smp_data), .xfer(start || reload), .match_clr(match_clr),
        .res8(res8), .run(run), .active(active), .cnt(cnt),
        .cmp_act(cmp_act), .buf_empty(buf_empty), .match_flag(match_flag)
    );

    // Requests are gated by run; the pulse is high while below the sample.
    always_comb begin
        irq     = run && ((buf_empty && ie_empty) || (match_flag && ie_match));
        dma_req = run && buf_empty;
        pulse   = run && active && (cnt < cmp_act);
        pwm_hi  = idle_lvl ^ pulse;
        pwm_lo  = ~pwm_hi;
    end

    // R11: a sample write withdraws the DMA request
    assert_dma_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        smp_wr |=> !dma_req);
    // R2: run with an empty buffer raises the DMA request
    assert_run_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && buf_empty && !soft_rst && !smp_wr && !(wr_en && wr_addr == 3'd1)) |=> dma_req);
endmodule

// File: tb/tb_audio_pwm_timer.sv
`timescale 1ns/1ps
module tb_audio_pwm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic buf_empty, match_flag, irq, dma_req, pwm_hi, pwm_lo;

    int checks = 0;
    int errors = 0;
    logic exp_idle = 1'b0;
    int widths [0:7];

    // Vector table: {idle level, sample, period limit}
    localparam logic [47:0] VECS [0:3] = '{
        {16'd0, 16'd3,  16'd9},
        {16'd1, 16'd5,  16'd7},
        {16'd0, 16'd1,  16'd2},
        {16'd1, 16'd12, 16'd12}
    };

    audio_pwm_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .buf_empty(buf_empty), .match_flag(match_flag),
        .irq(irq), .dma_req(dma_req), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Align to a period start, then count active cycles per period.
    task automatic measure(input int plen, input int n);
        int t;
        t = 0;
        while (pwm_hi !== exp_idle && t < 5000) begin @(negedge clk); t++; end
        while (pwm_hi === exp_idle && t < 5000) begin @(negedge clk); t++; end
        for (int p = 0; p < n; p++) begin
            int w;
            w = 0;
            for (int i = 0; i < plen; i++) begin
                if (pwm_hi !== exp_idle) w++;
                @(negedge clk);
            end
            widths[p] = w;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int bad;
        // Hard reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset pwm_hi", pwm_hi, 0);
        check("R10 reset pwm_lo", pwm_lo, 1);
        check("R1 reset buf_empty", buf_empty, 1);
        check("R1 reset irq", irq, 0);
        check("R1 reset dma_req", dma_req, 0);
        check("R1 reset match_flag", match_flag, 0);

        // Vector table walk: pulse width and period per configuration
        for (int v = 0; v < 4; v++) begin
            logic [15:0] smp, lim;
            exp_idle = VECS[v][32];
            smp = VECS[v][31:16];
            lim = VECS[v][15:0];
            wr(3'd0, {14'd0, exp_idle, 1'b1});
            check("R1 idle level after soft reset", pwm_hi, exp_idle);
            wr(3'd3, lim);
            wr(3'd4, 16'd0);
            wr(3'd1, 16'd1);
            wr(3'd2, smp);
            measure(int'(lim) + 1, 2);
            check("R4 width period 1", widths[0], int'(smp));
            check("R4 width period 2", widths[1], int'(smp));
            check("R4 period length", pwm_hi != exp_idle, 1);
            check("R10 complement while counting", pwm_lo, !pwm_hi);
        end

        // R2/R3/R11: run waits for a sample, then starts
        exp_idle = 1'b0;
        wr(3'd5, 16'd1);
        wr(3'd0, 16'd1);
        wr(3'd3, 16'd9);
        wr(3'd4, 16'd0);
        check("R1 soft reset irq quiet", irq, 0);
        check("R1 soft reset dma quiet", dma_req, 0);
        check("R1 soft reset buf_empty", buf_empty, 1);
        wr(3'd1, 16'd1);
        check("R2 irq after run", irq, 1);
        check("R2 dma_req after run", dma_req, 1);
        bad = 0;
        for (int i = 0; i < 6; i++) begin
            if (pwm_hi !== 1'b0) bad++;
            @(negedge clk);
        end
        check("R2 no counting before sample", bad, 0);
        wr(3'd2, 16'd3);
        check("R11 buf_empty cleared", buf_empty, 0);
        check("R11 dma_req cleared", dma_req, 0);
        check("R11 irq cleared", irq, 0);
        @(negedge clk);
        check("R3 buf_empty after start", buf_empty, 1);
        check("R3 dma_req after start", dma_req, 1);
        check("R3 irq after start", irq, 1);
        check("R3 output active at start", pwm_hi, 1);

        // R5/R6: delayed reload after a group, then value retained
        wr(3'd0, 16'd1);
        wr(3'd3, 16'd4);
        wr(3'd4, 16'd2);
        wr(3'd2, 16'd2);
        wr(3'd1, 16'd1);
        @(negedge clk);
        wr(3'd2, 16'd4);
        measure(5, 7);
        check("R5 old sample period 2", widths[0], 2);
        check("R5 old sample period 3", widths[1], 2);
        check("R5 new sample period 4", widths[2], 4);
        check("R5 new sample period 5", widths[3], 4);
        check("R6 kept sample period 6", widths[4], 4);
        check("R6 kept sample period 7", widths[5], 4);
        check("R6 kept sample period 8", widths[6], 4);
        check("R6 buffer stays empty", buf_empty, 1);

        // R9: stop forces idle, halts after group, restart waits for sample
        wr(3'd1, 16'd0);
        check("R9 pwm_hi idle on stop", pwm_hi, 0);
        check("R10 pwm_lo on stop", pwm_lo, 1);
        check("R9 dma_req dropped", dma_req, 0);
        idle_cycles(20);
        wr(3'd1, 16'd1);
        check("R9 dma_req on restart", dma_req, 1);
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            if (pwm_hi !== 1'b0) bad++;
            @(negedge clk);
        end
        check("R9 halted until new sample", bad, 0);
        wr(3'd2, 16'd1);
        measure(5, 2);
        check("R9 restart width", widths[0], 1);
        check("R9 restart width again", widths[1], 1);

        // R7: compare-hit flag, interrupt and clear
        wr(3'd5, 16'd2);
        wr(3'd0, 16'd1);
        wr(3'd3, 16'd9);
        wr(3'd4, 16'd0);
        wr(3'd1, 16'd1);
        check("R7 no irq with empty enable off", irq, 0);
        wr(3'd2, 16'd5);
        bad = 0;
        while (match_flag !== 1'b1 && bad < 30) begin @(negedge clk); bad++; end
        check("R7 match_flag set", match_flag, 1);
        check("R7 irq from match", irq, 1);
        wr(3'd6, 16'd1);
        check("R7 match_flag cleared", match_flag, 0);
        check("R7 irq cleared", irq, 0);

        // R1: soft reset while counting
        bad = 0;
        while (match_flag !== 1'b1 && bad < 30) begin @(negedge clk); bad++; end
        wr(3'd0, 16'd1);
        check("R1 mid-run buf_empty", buf_empty, 1);
        check("R1 mid-run match_flag", match_flag, 0);
        check("R1 mid-run irq", irq, 0);
        check("R1 mid-run dma_req", dma_req, 0);
        bad = 0;
        for (int i = 0; i < 15; i++) begin
            if (pwm_hi !== 1'b0) bad++;
            @(negedge clk);
        end
        check("R1 output held after soft reset", bad, 0);

        // R8: 8-bit resolution, sample in upper byte, no compare-hit flag
        wr(3'd0, 16'h0005);
        wr(3'd3, 16'd1023);
        wr(3'd1, 16'd1);
        wr(3'd2, 16'hFF02);
        measure(1024, 1);
        check("R8 upper-byte sample width", widths[0], 512);
        check("R8 match_flag stays clear", match_flag, 0);
        check("R8 irq stays clear", irq, 0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule